// File: doc/BRIEF.md
# Cascadable Loadable Binary Up-Counter

This block is a synchronous up-counter, four bits wide by default. Its register changes only on the rising clock edge. Each cycle, three control inputs choose one of four operations: clear, parallel load, count or hold. The next value of each bit comes from a toggle rule: a bit flips when every bit below it is one and counting is selected.

A carry output goes high whenever the register holds all ones. This output does not depend on the enable, so counters can be chained into a wider counter. In a chain, each higher stage counts only when the stage below it is enabled and its carry is high.

Internally, a priority selector turns the controls into an enumerated operation. The operation values are OP_CLEAR, OP_LOAD, OP_COUNT and OP_HOLD. One bit cell per bit applies the operation to its flip-flop, and a prefix-AND chain supplies the toggle conditions and the carry. There are no other states. The operation is re-chosen every cycle, with these transitions:

- clr=1 goes to OP_CLEAR.
- clr=0 and load=1 goes to OP_LOAD.
- clr=0, load=0 and en=1 goes to OP_COUNT.
- clr=0, load=0 and en=0 goes to OP_HOLD.

Top module: `casc_bin_counter`

## Requirements
- R1: `q` changes only at a rising edge of `clk`. Input changes between edges have no effect on `q` until the next rising edge.
- R2: When `clr`=1 at a rising edge, `q` becomes all zeros, whatever the values of `load`, `en` and `din`.
- R3: When `clr`=0 and `load`=1 at a rising edge, `q` takes `din`, with `din[WIDTH-1]` as the most significant bit. This happens whatever the value of `en`.
- R4: When `clr`=0, `load`=0 and `en`=1 at a rising edge, `q` increases by one. Bit i toggles exactly when bits 0 to i-1 are all one.
- R5: When `clr`=0, `load`=0 and `en`=0 at a rising edge, `q` keeps its value.
- R6: Counting from all ones wraps to all zeros.
- R7: `rco` is 1 exactly while `q` is all ones, whatever the value of `en`.
- R8: Two stages, with the upper stage's enable driven by `en` AND the lower stage's `rco`, behave as a single counter twice as wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear, highest priority |
| load | input | 1 | Synchronous parallel load |
| en | input | 1 | Count enable |
| din | input | WIDTH | Parallel load data, MSB first |
| q | output | WIDTH | Counter state |
| rco | output | 1 | High while q is all ones |

## Verification
The bench chains two stages into an 8-bit counter and compares them with a reference count.

- Random mixes of clear, load, enable and data show whether the priority order is right, because each of clr, load and en is exercised both alone and together with the others.
- Long runs with the enable held high make the carry ripple into the upper stage. This tells a correct toggle rule apart from a wrong prefix.
- Directed cases load values near all ones and then count through the wrap, checking the carry with the enable both high and low.
- Inputs are also changed mid-cycle to show that nothing happens between edges.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } cnt_op_e;
endpackage

// File: rtl/cnt_op_sel.sv
module cnt_op_sel
    import cnt_pkg::*;
(
    input  logic    clr,
    input  logic    load,
    input  logic    en,
    output cnt_op_e op
);
    // Priority: clear over load over count
    always_comb begin
        if (clr)       op = OP_CLEAR;
        else if (load) op = OP_LOAD;
        else if (en)   op = OP_COUNT;
        else           op = OP_HOLD;
    end
endmodule

// File: rtl/cnt_carry_chain.sv
module cnt_carry_chain #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] lower_ones,
    output logic             all_ones
);
    // lower_ones[i] is high when bits 0..i-1 are all one
    assign lower_ones[0] = 1'b1;
    for (genvar i = 1; i < WIDTH; i++) begin : g_prefix
        assign lower_ones[i] = lower_ones[i-1] & q[i-1];
    end
    assign all_ones = lower_ones[WIDTH-1] & q[WIDTH-1];
endmodule

// File: rtl/cnt_bit_cell.sv
module cnt_bit_cell
    import cnt_pkg::*;
(
    input  logic    clk,
    input  cnt_op_e op,
    input  logic    lower_ones,
    input  logic    d_bit,
    output logic    q_bit
);
    logic nxt;

    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = 1'b0;
            OP_LOAD:  nxt = d_bit;
            OP_COUNT: nxt = q_bit ^ lower_ones;
            OP_HOLD:  nxt = q_bit;
            default:  nxt = q_bit;
        endcase
    end

    always_ff @(posedge clk) begin
        q_bit <= nxt;
    end
endmodule

// File: rtl/casc_bin_counter.sv
module casc_bin_counter
    import cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             load,
    input  logic             en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q,
    output logic             rco
);
    cnt_op_e          op;
    logic [WIDTH-1:0] lower_ones;
    logic             all_ones;

    cnt_op_sel u_sel (
        .clr  (clr),
        .load (load),
        .en   (en),
        .op   (op)
    );

    cnt_carry_chain #(.WIDTH(WIDTH)) u_chain (
        .q          (q),
        .lower_ones (lower_ones),
        .all_ones   (all_ones)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        cnt_bit_cell u_cell (
            .clk        (clk),
            .op         (op),
            .lower_ones (lower_ones[i]),
            .d_bit      (din[i]),
            .q_bit      (q[i])
        );
    end

    always_comb begin
        rco = all_ones;
    end

    // R2: clear wins over every other control
    a_r2_clear_zero: assert property (@(posedge clk) disable iff (1'b0)
        clr |=> (q == '0));

    // R3: load copies the data word
    a_r3_load_copy: assert property (@(posedge clk) disable iff (clr)
        (load) |=> (q == $past(din)));

    // R4 and R6: counting adds one modulo 2**WIDTH
    a_r4_count_step: assert property (@(posedge clk) disable iff (clr)
        (!load && en) |=> (q == WIDTH'($past(q) + 1'b1)));

    // R5: hold keeps the value
    a_r5_hold_keep: assert property (@(posedge clk) disable iff (clr)
        (!load && !en) |=> $stable(q));

    // R7: carry tracks the all-ones state only
    a_r7_rco_all_ones: assert property (@(posedge clk) disable iff (clr)
        rco == ($countones(q) == WIDTH));
endmodule

// File: tb/casc_bin_counter_tb_top.sv
module casc_bin_counter_tb_top;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         clr = 1'b0, load = 1'b0, en = 1'b0;
    logic [2*W-1:0] din = '0;
    logic [W-1:0] q_lo, q_hi;
    logic         rco_lo, rco_hi;
    logic [2*W-1:0] ref_q = '0;
    int           n_vec = 0, n_fail = 0;
    bit           done = 0;

    always #4 clk = ~clk;

    casc_bin_counter #(.WIDTH(W)) dut_i (
        .clk(clk), .clr(clr), .load(load), .en(en),
        .din(din[W-1:0]), .q(q_lo), .rco(rco_lo));

    casc_bin_counter #(.WIDTH(W)) dut_hi_i (
        .clk(clk), .clr(clr), .load(load), .en(en & rco_lo),
        .din(din[2*W-1:W]), .q(q_hi), .rco(rco_hi));

    function automatic logic [2*W-1:0] model(input logic [2*W-1:0] cur,
            input logic c, input logic l, input logic e, input logic [2*W-1:0] d);
        if (c)      return '0;
        else if (l) return d;
        else if (e) return cur + 1'b1;
        else        return cur;
    endfunction

    task automatic check(input string tag, input logic [2*W-1:0] act,
                         input logic [2*W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive at negedge, clock once, compare at the following negedge
    task automatic step(input logic c, input logic l, input logic e,
                        input logic [2*W-1:0] d, input string tag);
        clr = c; load = l; en = e; din = d;
        ref_q = model(ref_q, c, l, e, d);
        @(negedge clk);
        check(tag, {q_hi, q_lo}, ref_q);
        check({tag, " R7 rco_lo"}, {7'd0, rco_lo}, {7'd0, ref_q[W-1:0] == 4'hF});
        check({tag, " R7 rco_hi"}, {7'd0, rco_hi}, {7'd0, ref_q[2*W-1:W] == 4'hF});
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        step(1, 0, 0, 8'h00, "R2 reset clear");
        step(1, 1, 1, 8'hA5, "R2 clear beats load/en");
        step(0, 1, 1, 8'h3C, "R3 load beats en");
        // R1: mid-cycle input change must not move q
        clr = 1; load = 1; din = 8'h77;
        #2;
        check("R1 no change between edges", {q_hi, q_lo}, 8'h3C);
        step(0, 0, 0, 8'h99, "R5 hold");
        step(0, 1, 0, 8'hFE, "R3 load FE");
        step(0, 0, 1, 8'h00, "R4 count to FF");
        step(0, 0, 0, 8'h00, "R7 rco with en low");
        step(0, 0, 1, 8'h00, "R6 wrap to 00");
        step(0, 1, 0, 8'h0E, "R3 load 0E");
        step(0, 0, 1, 8'h00, "R4 count 0F");
        step(0, 0, 1, 8'h00, "R8 carry into upper");
        for (int i = 0; i < 600; i++) step(0, 0, 1, 8'h00, "R8 long count");
        for (int i = 0; i < 3000; i++) begin
            automatic int r = $urandom_range(0, 99);
            automatic logic c = (r < 4);
            automatic logic l = (r >= 4 && r < 12) || ($urandom_range(0, 19) == 0);
            automatic logic e = ($urandom_range(0, 9) < 8);
            automatic logic [7:0] d = 8'($urandom);
            if ($urandom_range(0, 9) == 0) d = {4'hF, 4'($urandom_range(13, 15))};
            step(c, l, e, d, "R2-R8 random");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule